// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Level and Idle Timeout

This block sits between the bit-level deserialiser of a 16550-style serial port and the CPU register file. Every byte the deserialiser hands over, and every line-break event, enters a 16-byte circular queue. The CPU drains the queue one byte per read strobe. The data at the head of the queue is always visible on `rd_data`, so a read strobe samples the byte that is present in the same cycle.

The same block owns the queue control register. Writes to this register are decoded into four things: queue enable, a one-shot receive flush, a one-shot transmit flush that is handed to the transmit side, and a four-step receive trigger level. The retained configuration is exported to the interrupt logic, together with a level-reached flag.

An idle detector measures four character times in bit-time ticks. The length of a character is taken from the configured frame format. When that time passes with no queue activity and data is still waiting, a timeout-pending flag is raised.

Top module: `serial_rxq`

## Requirements
- R1: With the queue enabled it holds up to 16 bytes and returns them in arrival order. With it disabled it holds at most one byte. `rx_count` always gives the number held and `data_ready` is high whenever that number is nonzero.
- R2: A control write keeps only bit 0 (enable, on `fifo_en`), bit 3 (`dma_mode`) and bits 7:6 (trigger select). Bits 7:6 map 00, 01, 10, 11 to trigger levels 1, 4, 8, 14 on `trig_lvl`. `level_hit` is high when the queue is enabled and the count is at least the trigger level.
- R3: Control bit 1 flushes the receive queue. Control bit 2 drives `tx_clr` high during the write cycle. Neither bit is retained, so writing the retained value again afterwards counts as an identical write.
- R4: A control write whose bit 0 differs from the stored enable flushes the receive queue and raises `tx_clr`, whatever bits 1 and 2 hold. A write equal to the stored 8-bit value has no effect at all.
- R5: A receive flush empties the queue and clears the timeout state, the pending flag and the break flag. Any byte arriving in the same cycle is dropped.
- R6: A read strobe on a non-empty queue removes the head byte and clears the pending flag. If the queue becomes empty, the break flag clears and the idle timer stops. Otherwise, with the queue enabled, the idle timer restarts.
- R7: Each accepted byte restarts the idle timer when the queue is enabled. If the timer then runs out while data is waiting, `tmo_pend` goes high.
- R8: A read strobe on an empty queue shows 0x00 on `rd_data` and changes no state.
- R9: The idle limit is 4 × (1 start + 5+`frm_dlen` data + `frm_par` + 1 or 2 stop, as set by `frm_stop2`) counted on `bit_tick`.
- R10: A byte that arrives while the queue is full is discarded and `ovr` is high in that cycle. A read in the same cycle frees a slot, so the byte is then accepted.
- R11: A `rx_brk` event enqueues the byte 0x00 and sets `brk_flag`. It takes precedence over `rx_valid` in the same cycle.
- R12: In a single cycle a flush overrides reads and arrivals, and a timer restart overrides a timer expiry.
- R13: While the queue is disabled the idle timer never starts, so `tmo_pend` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| rx_valid | input | 1 | Deserialiser byte strobe |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Line-break event strobe |
| rd_pop | input | 1 | CPU read strobe for the receive buffer |
| rd_data | output | 8 | Head byte, or 0x00 when empty |
| bit_tick | input | 1 | One pulse per bit time |
| frm_dlen | input | 2 | Data bits minus five |
| frm_par | input | 1 | Parity bit present |
| frm_stop2 | input | 1 | Two stop bits |
| fifo_en | output | 1 | Queue enabled |
| dma_mode | output | 1 | Retained DMA select bit |
| trig_lvl | output | 5 | Trigger level in bytes |
| level_hit | output | 1 | Count at or above trigger level |
| tx_clr | output | 1 | Transmit flush pulse |
| data_ready | output | 1 | Queue not empty |
| rx_count | output | 5 | Bytes held |
| brk_flag | output | 1 | Break byte received and not yet drained |
| tmo_pend | output | 1 | Idle timeout pending |
| ovr | output | 1 | Arrival discarded this cycle |

## Verification
The collisions that matter here are a read and an arrival landing together, and an idle-timer expiry landing together with a timer restart. A read and an arrival meet both on a full queue, where the read has to make room, and on a nearly empty one, where the break flag and the timer have to follow the resulting count. For the second collision, the bench counts ticks exactly so that a byte arrives, or a read is made, in the very cycle the timer would run out. It then checks that no pending flag appears. A behavioural queue model compares every output on every cycle, both in these directed cases and in a long random run that mixes control writes in as well, so a flush also meets traffic.

// File: rtl/serial_rxq_pkg.sv
package serial_rxq_pkg;

  // Longest frame: start + 8 data + parity + 2 stop.
  localparam int FRAME_MAX = 12;

  // Bits in one character on the line for the given frame setting.
  function automatic int char_bits(logic [1:0] dlen, logic par, logic stop2);
    return 7 + int'(dlen) + int'(par) + int'(stop2);
  endfunction

  // Trigger select (control bits 7:6) to a level in bytes.
  function automatic int trig_decode(logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/serial_rxq_ctl.sv
module serial_rxq_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] cfg_q,
  output logic       rx_flush,
  output logic       tx_flush
);
  localparam logic [7:0] KEEP_MASK = 8'hC9;
  localparam int EN_B  = 0;
  localparam int RXR_B = 1;
  localparam int TXR_B = 2;

  logic wr_eff;
  logic en_chg;

  assign wr_eff   = wr && (wdata != cfg_q);
  assign en_chg   = wdata[EN_B] ^ cfg_q[EN_B];
  assign rx_flush = wr_eff && (wdata[RXR_B] || en_chg);
  assign tx_flush = wr_eff && (wdata[TXR_B] || en_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_eff) cfg_q <= wdata & KEEP_MASK;
  end

  AST_SAME_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == cfg_q) |=> $stable(cfg_q)); // R4

endmodule

// File: rtl/serial_rxq_store.sv
module serial_rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [DW-1:0] head,
  output logic          do_push,
  output logic          do_pop,
  output logic          ovr_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          cap_full;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap_full = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign do_pop   = pop && (count != '0);
  assign do_push  = push && (!cap_full || do_pop);
  assign ovr_o    = push && !do_push && !flush;
  assign head     = (count != '0) ? mem[rd_ptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !flush) |=> $stable(rd_ptr)); // R8
  AST_OVR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !pop) |=> $stable(count)); // R10

endmodule

// File: rtl/serial_rxq_tmo.sv
module serial_rxq_tmo #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          arm,
  input  logic          disarm,
  input  logic          clr_pend,
  input  logic          nonempty,
  output logic          pend,
  output logic          expire
);
  logic          armed;
  logic [TW-1:0] cnt;

  assign expire = armed && tick && (cnt == limit - 1'b1) && !flush && !arm && !disarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      pend  <= 1'b0;
    end else if (flush) begin
      armed <= 1'b0;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      if (clr_pend) pend <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (disarm) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (expire) begin
        armed <= 1'b0;
        cnt   <= '0;
        if (nonempty) pend <= 1'b1;
      end else if (armed && tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PEND_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> nonempty); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !pend); // R6
  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && nonempty && !clr_pend) |=> pend); // R7

endmodule

// File: rtl/serial_rxq.sv
module serial_rxq #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int TW      = $clog2(TO_CHARS * serial_rxq_pkg::FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_brk,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  input  logic          bit_tick,
  input  logic [1:0]    frm_dlen,
  input  logic          frm_par,
  input  logic          frm_stop2,
  output logic          fifo_en,
  output logic          dma_mode,
  output logic [CW-1:0] trig_lvl,
  output logic          level_hit,
  output logic          tx_clr,
  output logic          data_ready,
  output logic [CW-1:0] rx_count,
  output logic          brk_flag,
  output logic          tmo_pend,
  output logic          ovr
);
  import serial_rxq_pkg::*;

  logic [7:0]    cfg_q;
  logic          rx_flush;
  logic          push;
  logic [DW-1:0] push_data;
  logic          do_push;
  logic          do_pop;
  logic [CW-1:0] count_after;
  logic          tmr_arm;
  logic          tmr_disarm;
  logic          tmr_expire;
  logic [TW-1:0] tmr_limit;

  serial_rxq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .cfg_q    (cfg_q),
    .rx_flush (rx_flush),
    .tx_flush (tx_clr)
  );

  assign fifo_en   = cfg_q[0];
  assign dma_mode  = cfg_q[3];
  assign trig_lvl  = CW'(trig_decode(cfg_q[7:6]));
  assign push      = rx_valid || rx_brk;
  assign push_data = rx_brk ? '0 : rx_data;

  serial_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .cap_one   (!fifo_en),
    .push      (push),
    .push_data (push_data),
    .pop       (rd_pop),
    .count     (rx_count),
    .head      (rd_data),
    .do_push   (do_push),
    .do_pop    (do_pop),
    .ovr_o     (ovr)
  );

  assign count_after = rx_count + CW'(do_push) - CW'(do_pop);
  assign tmr_arm     = fifo_en && (do_push || (do_pop && count_after != '0));
  assign tmr_disarm  = do_pop && (count_after == '0);
  assign tmr_limit   = TW'(TO_CHARS * char_bits(frm_dlen, frm_par, frm_stop2));

  serial_rxq_tmo #(.TW(TW)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (rx_flush),
    .tick     (bit_tick),
    .limit    (tmr_limit),
    .arm      (tmr_arm),
    .disarm   (tmr_disarm),
    .clr_pend (do_pop),
    .nonempty (rx_count != '0),
    .pend     (tmo_pend),
    .expire   (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  brk_flag <= 1'b0;
    else if (rx_flush)           brk_flag <= 1'b0;
    else if (do_push && rx_brk)  brk_flag <= 1'b1;
    else if (tmr_disarm)         brk_flag <= 1'b0;
  end

  assign data_ready = (rx_count != '0);
  assign level_hit  = fifo_en && (rx_count >= trig_lvl);

  AST_TOGGLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != $past(fifo_en)) |-> (rx_count == '0)); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_count == '0 && !tmo_pend && !brk_flag)); // R5
  AST_DIS_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !tmo_pend); // R13
  AST_BRK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    brk_flag |-> data_ready); // R11

endmodule

// File: tb/test_serial_rxq.sv
module test_serial_rxq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_brk = 1'b0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       bit_tick = 1'b0;
  logic [1:0] frm_dlen = 2'd3;
  logic       frm_par = 1'b0;
  logic       frm_stop2 = 1'b0;
  logic       fifo_en, dma_mode, level_hit, tx_clr, data_ready, brk_flag, tmo_pend, ovr;
  logic [4:0] trig_lvl, rx_count;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  serial_rxq i_serial_rxq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk), .rd_pop(rd_pop),
    .rd_data(rd_data), .bit_tick(bit_tick), .frm_dlen(frm_dlen), .frm_par(frm_par),
    .frm_stop2(frm_stop2), .fifo_en(fifo_en), .dma_mode(dma_mode), .trig_lvl(trig_lvl),
    .level_hit(level_hit), .tx_clr(tx_clr), .data_ready(data_ready), .rx_count(rx_count),
    .brk_flag(brk_flag), .tmo_pend(tmo_pend), .ovr(ovr)
  );

  // Behavioural reference
  logic [7:0] mq[$];
  bit         m_brk, m_armed, m_pend;
  int         m_tcnt;
  logic [7:0] m_cfg;
  bit         u_weff, u_chg, u_rfl, u_pop, u_push;
  int         u_cap, u_lim;

  function automatic int frame_len(logic [1:0] dl, logic p, logic s2);
    int data_bits = int'(dl) + 5;
    return 1 + data_bits + (p ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_brk = 0; m_armed = 0; m_tcnt = 0; m_pend = 0; m_cfg = '0;
    end else begin
      u_weff = ctl_wr && (ctl_wdata != m_cfg);
      u_chg  = ctl_wdata[0] != m_cfg[0];
      u_rfl  = u_weff && (ctl_wdata[1] || u_chg);
      u_cap  = m_cfg[0] ? 16 : 1;
      u_lim  = 4 * frame_len(frm_dlen, frm_par, frm_stop2);
      if (u_rfl) begin
        mq.delete(); m_brk = 0; m_armed = 0; m_tcnt = 0; m_pend = 0;
      end else begin
        u_pop  = rd_pop && mq.size() > 0;
        u_push = (rx_valid || rx_brk) && (mq.size() < u_cap || u_pop);
        if (u_pop) void'(mq.pop_front());
        if (u_push) mq.push_back(rx_brk ? 8'h00 : rx_data);
        if (u_push && rx_brk) m_brk = 1;
        else if (u_pop && mq.size() == 0) m_brk = 0;
        if (u_pop) m_pend = 0;
        if (m_cfg[0] && (u_push || (u_pop && mq.size() > 0))) begin
          m_armed = 1; m_tcnt = 0;
        end else if (u_pop && mq.size() == 0) begin
          m_armed = 0; m_tcnt = 0;
        end else if (m_armed && bit_tick) begin
          if (m_tcnt == u_lim - 1) begin
            m_armed = 0; m_tcnt = 0;
            if (mq.size() > 0) m_pend = 1;
          end else m_tcnt++;
        end
      end
      if (u_weff) m_cfg = ctl_wdata & 8'hC9;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int sz, tl, cap;
      bit weff, chg, pok, e_ovr, e_tx;
      int tlv[4] = '{1, 4, 8, 14};
      sz   = mq.size();
      tl   = tlv[m_cfg[7:6]];
      cap  = m_cfg[0] ? 16 : 1;
      weff = ctl_wr && (ctl_wdata != m_cfg);
      chg  = ctl_wdata[0] != m_cfg[0];
      pok  = rd_pop && sz > 0;
      e_ovr = (rx_valid || rx_brk) && !(weff && (ctl_wdata[1] || chg)) && !(sz < cap || pok);
      e_tx  = weff && (ctl_wdata[2] || chg);
      chk(int'(rx_count) == sz, "R1 R5 R12", "count", rx_count, sz);
      chk(data_ready == (sz > 0), "R1 R6", "data_ready", data_ready, sz > 0);
      chk(int'(rd_data) == (sz > 0 ? int'(mq[0]) : 0), "R6 R8", "rd_data", rd_data, sz > 0 ? mq[0] : 0);
      chk(fifo_en == m_cfg[0] && dma_mode == m_cfg[3], "R2 R4", "cfg", {fifo_en, dma_mode}, {m_cfg[0], m_cfg[3]});
      chk(int'(trig_lvl) == tl, "R2", "trig_lvl", trig_lvl, tl);
      chk(level_hit == (m_cfg[0] && sz >= tl), "R2", "level_hit", level_hit, m_cfg[0] && sz >= tl);
      chk(tx_clr == e_tx, "R3 R4", "tx_clr", tx_clr, e_tx);
      chk(brk_flag == m_brk, "R11", "brk_flag", brk_flag, m_brk);
      chk(tmo_pend == m_pend, "R7 R9 R12 R13", "tmo_pend", tmo_pend, m_pend);
      chk(ovr == e_ovr, "R10", "ovr", ovr, e_ovr);
    end
  end

  task automatic cyc(input bit wr, input logic [7:0] wd, input bit rv, input logic [7:0] rd,
                     input bit brk, input bit pop, input bit tk);
    @(posedge clk); #2;
    ctl_wr = wr; ctl_wdata = wd; rx_valid = rv; rx_data = rd;
    rx_brk = brk; rd_pop = pop; bit_tick = tk;
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 8'h00, 0, 0, tk);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(2, 0);
    // R1 R10 R8: disabled mode holds one byte
    cyc(0, 0, 1, 8'hA1, 0, 0, 0);
    cyc(0, 0, 1, 8'hB2, 0, 0, 0);
    cyc(0, 0, 1, 8'hC3, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R2 R4: enable with trigger 4
    cyc(1, 8'h41, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'(8'h10 + i), 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R7 R9: timeout expiry, 10-bit frame
    idle(45, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    // R9: 12-bit frame
    frm_par = 1; frm_stop2 = 1;
    cyc(0, 0, 1, 8'h55, 0, 0, 1);
    idle(52, 1);
    // R10: fill to full and overflow, then arrival plus read when full
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 8'(8'h80 + i), 0, 0, 0);
    cyc(0, 0, 1, 8'hEE, 0, 1, 0);
    // R4 R3: identical write, tx-only flush, rx flush
    cyc(1, 8'h41, 0, 0, 0, 0, 0);
    cyc(1, 8'h45, 0, 0, 0, 0, 0);
    cyc(1, 8'h41, 0, 0, 0, 0, 0);
    cyc(1, 8'hCB, 1, 8'h77, 0, 1, 0);
    cyc(1, 8'hC9, 0, 0, 0, 0, 0);
    // R11: break event
    cyc(0, 0, 1, 8'h99, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R12: expiry meets arrival, then expiry meets read (7-bit frame, 28 ticks)
    frm_dlen = 0; frm_par = 0; frm_stop2 = 0;
    cyc(0, 0, 1, 8'h31, 0, 0, 1);
    idle(27, 1);
    cyc(0, 0, 1, 8'h32, 0, 0, 1);
    idle(27, 1);
    cyc(0, 0, 0, 0, 0, 1, 1);
    idle(30, 1);
    // R4 R13: toggle enable off while data waits
    cyc(0, 0, 1, 8'h44, 0, 0, 0);
    cyc(1, 8'hC8, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 8'h45, 0, 0, 1);
    idle(60, 1);
    // Random traffic across all functions
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        frm_dlen = 2'($urandom_range(0, 3));
        frm_par = 1'($urandom_range(0, 1));
        frm_stop2 = 1'($urandom_range(0, 1));
      end
      cyc($urandom_range(0, 79) == 0, 8'($urandom_range(0, 255)),
          $urandom_range(0, 2) == 0, 8'($urandom_range(0, 255)),
          $urandom_range(0, 59) == 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 0);
    end
    idle(3, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule